// File: doc/BRIEF.md
# Two-Channel Timeslot Serial Port

This block is a serial port for a 2B+D style link. A frame sync pulse and a data clock define a frame. Each frame carries two bearer slots, B1 and B2, one after the other. One data bit lasts two data-clock cycles, so the bit rate is half the clock rate. A slot holds an 8-bit byte and lasts sixteen clock cycles. B1 takes clock cycles 0 to 15 of the frame and B2 takes cycles 16 to 31.

A channel-select input chooses which of the two slots the port uses, for both directions. During the chosen slot the port sends a parallel byte out serially, MSB first, and raises an output-enable. The enable is low at every other time, so a pad can hold the line in high impedance. In the same slot the port shifts in the receive line and presents the assembled byte with a one-cycle valid strobe.

The logic runs entirely on rising edges of the data clock, and the frame sync is sampled on those same edges.

Top module: `gci_slot_port`

## Requirements
- R1: After the synchronous reset, `tx_oe`, `tx_data` and `rx_valid` are low and `rx_byte` is zero. They stay that way until the first rising edge of `fsync` after reset. A `fsync` that is already high when reset is released does not count as that edge.
- R2: Cycle 0 of a frame is the cycle that follows the first clock edge at which `fsync` is sampled high after having been sampled low. If `fsync` stays high for several cycles, the frame does not restart. A new rising edge restarts the count at cycle 0.
- R3: Each bit lasts two clock cycles. `tx_data` may change only when entering an even cycle, counted from the start of the slot.
- R4: `sel_b2` = 0 selects the slot in frame cycles 0 to 15. `sel_b2` = 1 selects the slot in cycles 16 to 31. The value is taken at the cycle-0 edge and held for the whole frame; later changes are ignored.
- R5: `tx_oe` is high in exactly the sixteen cycles of the selected slot and low at all other times. `tx_data` is 0 whenever `tx_oe` is low.
- R6: `tx_byte` is captured at the cycle-0 edge and sent MSB first. Bit 7 is sent in slot cycles 0 and 1, and bit i in slot cycles 2(7-i) and 2(7-i)+1. Later changes to `tx_byte` do not affect the frame.
- R7: `rx_data` is sampled at the edge that opens slot cycle 2b+1, the second cycle of bit b. The first bit sampled is the MSB of `rx_byte`. Values on `rx_data` at any other edge, inside or outside the slot, are ignored.
- R8: `rx_valid` is high for exactly one cycle, the last cycle of the selected slot (slot cycle 15). `rx_byte` then holds the received byte until the next strobe.
- R9: The frame cycle counter saturates at `FRAME_LIMIT`. Frames longer than 32 cycles produce no slot activity after cycle 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock; all logic on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync; rising edge starts a frame |
| sel_b2 | input | 1 | Slot select: 0 = B1, 1 = B2 |
| tx_byte | input | BITS | Byte to send in the selected slot |
| rx_data | input | 1 | Serial receive line |
| tx_data | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Transmit output-enable (low = high impedance) |
| rx_byte | output | BITS | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_byte` |

## Verification
Some properties can be checked on every cycle: `tx_data` is low while `tx_oe` is low, `tx_data` holds during the second cycle of each bit, `rx_valid` is a one-cycle pulse that only falls on the last cycle of a slot, and `tx_oe` never rises before a frame has started. Other behaviour needs the bench's scenarios to show it. These include slot placement for each select value, the MSB-first bit order, latching of the byte and the select at frame start, and mid-bit sampling. The bench shows mid-bit sampling by driving a wrong value on `rx_data` during the first cycle of each bit. The bench also covers sync pulses of varied width, long frames, and a reset while `fsync` is held high.

// File: rtl/gci_pkg.sv
package gci_pkg;
  typedef enum logic {
    SLOT_B1 = 1'b0,
    SLOT_B2 = 1'b1
  } slot_e;
endpackage

// File: rtl/gci_frame_timer.sv
module gci_frame_timer
  import gci_pkg::*;
#(
  parameter int CW          = 8,
  parameter int SLOT_CYCLES = 16,
  parameter int FRAME_LIMIT = 255
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fsync,
  input  logic          sel_b2,
  output logic          rise,
  output logic [CW-1:0] cyc_nxt,
  output logic          act_nxt,
  output logic [CW-1:0] base_nxt,
  output logic [CW-1:0] cyc_q,
  output logic          act_q,
  output logic [CW-1:0] base_q
);
  localparam logic [CW-1:0] LIMIT = CW'(FRAME_LIMIT);

  logic  fs_q;
  slot_e slot_q, slot_nxt;

  assign rise     = fsync & ~fs_q;
  assign act_nxt  = rise | act_q;
  assign slot_nxt = rise ? slot_e'(sel_b2) : slot_q;
  assign base_nxt = (slot_nxt == SLOT_B2) ? CW'(SLOT_CYCLES) : '0;

  always_comb begin
    if (rise)               cyc_nxt = '0;
    else if (cyc_q == LIMIT) cyc_nxt = cyc_q;
    else                    cyc_nxt = cyc_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q   <= 1'b1;
      act_q  <= 1'b0;
      cyc_q  <= LIMIT;
      slot_q <= SLOT_B1;
      base_q <= '0;
    end else begin
      fs_q   <= fsync;
      act_q  <= act_nxt;
      cyc_q  <= cyc_nxt;
      slot_q <= slot_nxt;
      base_q <= base_nxt;
    end
  end

  a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
    (cyc_q == LIMIT && !fsync) |=> (cyc_q == LIMIT));
endmodule

// File: rtl/gci_tx_slot.sv
module gci_tx_slot #(
  parameter int CW          = 8,
  parameter int BITS        = 8,
  parameter int CYC_PER_BIT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rise,
  input  logic [BITS-1:0] tx_byte,
  input  logic [CW-1:0]   cyc_nxt,
  input  logic            act_nxt,
  input  logic [CW-1:0]   base_nxt,
  input  logic [CW-1:0]   cyc_q,
  output logic            tx_data,
  output logic            tx_oe
);
  localparam int SLOT_CYCLES = BITS * CYC_PER_BIT;
  localparam int IW          = (BITS > 1) ? $clog2(BITS) : 1;

  logic [BITS-1:0] hold_q, byte_use;
  logic [CW-1:0]   off;
  logic [IW-1:0]   idx;
  logic            in_slot;

  assign byte_use = rise ? tx_byte : hold_q;
  assign in_slot  = act_nxt && (cyc_nxt >= base_nxt) &&
                    (cyc_nxt < base_nxt + CW'(SLOT_CYCLES));
  assign off      = cyc_nxt - base_nxt;
  assign idx      = IW'(off / CW'(CYC_PER_BIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      tx_oe   <= 1'b0;
      tx_data <= 1'b0;
    end else begin
      if (rise) hold_q <= tx_byte;
      tx_oe   <= in_slot;
      tx_data <= in_slot ? byte_use[IW'(BITS-1) - idx] : 1'b0;
    end
  end

  a_r5_quiet_low: assert property (@(posedge clk) disable iff (rst)
    !tx_oe |-> !tx_data);

  a_r3_bit_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_oe && $past(tx_oe) && cyc_q[0]) |-> $stable(tx_data));
endmodule

// File: rtl/gci_rx_slot.sv
module gci_rx_slot #(
  parameter int CW          = 8,
  parameter int BITS        = 8,
  parameter int CYC_PER_BIT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_data,
  input  logic [CW-1:0]   cyc_nxt,
  input  logic            act_nxt,
  input  logic [CW-1:0]   base_nxt,
  input  logic [CW-1:0]   cyc_q,
  input  logic [CW-1:0]   base_q,
  output logic [BITS-1:0] rx_byte,
  output logic            rx_valid
);
  localparam int SLOT_CYCLES = BITS * CYC_PER_BIT;

  logic [BITS-1:0] shift_q;
  logic [CW-1:0]   off;
  logic            in_slot, sample, last;

  assign in_slot = act_nxt && (cyc_nxt >= base_nxt) &&
                   (cyc_nxt < base_nxt + CW'(SLOT_CYCLES));
  assign off     = cyc_nxt - base_nxt;
  assign sample  = in_slot && ((off % CW'(CYC_PER_BIT)) == CW'(CYC_PER_BIT - 1));
  assign last    = sample && (off == CW'(SLOT_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q  <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= last;
      if (sample) shift_q <= {shift_q[BITS-2:0], rx_data};
      if (last)   rx_byte <= {shift_q[BITS-2:0], rx_data};
    end
  end

  a_r8_valid_at_end: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (cyc_q == base_q + CW'(SLOT_CYCLES - 1)));

  a_r8_byte_hold: assert property (@(posedge clk) disable iff (rst)
    !rx_valid && !$past(rst) |-> $stable(rx_byte));
endmodule

// File: rtl/gci_slot_port.sv
module gci_slot_port #(
  parameter int BITS        = 8,
  parameter int CYC_PER_BIT = 2,
  parameter int FRAME_LIMIT = 255
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fsync,
  input  logic            sel_b2,
  input  logic [BITS-1:0] tx_byte,
  input  logic            rx_data,
  output logic            tx_data,
  output logic            tx_oe,
  output logic [BITS-1:0] rx_byte,
  output logic            rx_valid
);
  localparam int SLOT_CYCLES = BITS * CYC_PER_BIT;
  localparam int CW          = $clog2(FRAME_LIMIT + 1);

  logic          rise, act_nxt, act_q;
  logic [CW-1:0] cyc_nxt, base_nxt, cyc_q, base_q;

  gci_frame_timer #(
    .CW(CW), .SLOT_CYCLES(SLOT_CYCLES), .FRAME_LIMIT(FRAME_LIMIT)
  ) timer_i (
    .clk(clk), .rst(rst), .fsync(fsync), .sel_b2(sel_b2),
    .rise(rise), .cyc_nxt(cyc_nxt), .act_nxt(act_nxt), .base_nxt(base_nxt),
    .cyc_q(cyc_q), .act_q(act_q), .base_q(base_q)
  );

  gci_tx_slot #(
    .CW(CW), .BITS(BITS), .CYC_PER_BIT(CYC_PER_BIT)
  ) tx_i (
    .clk(clk), .rst(rst), .rise(rise), .tx_byte(tx_byte),
    .cyc_nxt(cyc_nxt), .act_nxt(act_nxt), .base_nxt(base_nxt), .cyc_q(cyc_q),
    .tx_data(tx_data), .tx_oe(tx_oe)
  );

  gci_rx_slot #(
    .CW(CW), .BITS(BITS), .CYC_PER_BIT(CYC_PER_BIT)
  ) rx_i (
    .clk(clk), .rst(rst), .rx_data(rx_data),
    .cyc_nxt(cyc_nxt), .act_nxt(act_nxt), .base_nxt(base_nxt),
    .cyc_q(cyc_q), .base_q(base_q),
    .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  a_r1_no_oe_idle: assert property (@(posedge clk) disable iff (rst)
    !act_q |-> !tx_oe);
endmodule

// File: tb/gci_slot_port_tb.sv
module gci_slot_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT       = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fsync = 1'b0;
  logic       sel_b2 = 1'b0;
  logic [7:0] tx_byte = '0;
  logic       rx_data = 1'b0;
  logic       tx_data, tx_oe, rx_valid;
  logic [7:0] rx_byte;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] last_rx = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gci_slot_port dut_i (
    .clk(clk), .rst(rst), .fsync(fsync), .sel_b2(sel_b2), .tx_byte(tx_byte),
    .rx_data(rx_data), .tx_data(tx_data), .tx_oe(tx_oe),
    .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_oe(input int k, input bit sel);
    int s = sel ? SLOT : 0;
    return (k >= s) && (k < s + SLOT);
  endfunction

  function automatic bit exp_tx(input int k, input bit sel, input logic [7:0] b);
    int s = sel ? SLOT : 0;
    if (!exp_oe(k, sel)) return 1'b0;
    return b[7 - (k - s) / 2];
  endfunction

  function automatic bit rx_drive(input int k, input bit sel, input logic [7:0] b);
    int s = sel ? SLOT : 0;
    if (!exp_oe(k, sel)) return 1'($urandom);
    if (((k - s) % 2) == 0) return ~b[7 - (k - s) / 2];
    return b[7 - (k - s) / 2];
  endfunction

  task automatic quiet_check(input string req);
    check(req, tx_oe, 0, "tx_oe idle");
    check(req, tx_data, 0, "tx_data idle");
    check(req, rx_valid, 0, "rx_valid idle");
  endtask

  task automatic run_frame(input int flen, input int fs_hi, input bit sel,
                           input logic [7:0] tb, input logic [7:0] rb);
    for (int k = 0; k < flen; k++) begin
      @(negedge clk);
      fsync = (k < fs_hi);
      if (k == 0) begin
        sel_b2  = sel;
        tx_byte = tb;
      end else begin
        sel_b2  = 1'($urandom);
        tx_byte = 8'($urandom);
      end
      rx_data = rx_drive(k, sel, rb);
      @(posedge clk);
      #1;
      check(sel ? "R4" : "R5", tx_oe, exp_oe(k, sel), $sformatf("tx_oe cycle %0d", k));
      check(k >= 2 * SLOT ? "R9" : "R6", tx_data, exp_tx(k, sel, tb),
            $sformatf("tx_data cycle %0d", k));
      check("R8", rx_valid, (k == (sel ? SLOT : 0) + SLOT - 1),
            $sformatf("rx_valid cycle %0d", k));
      if (rx_valid) begin
        check("R7", rx_byte, rb, "rx_byte at strobe");
        last_rx = rb;
      end else begin
        check("R8", rx_byte, last_rx, "rx_byte hold");
      end
    end
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    #1;
    quiet_check("R1");
    check("R1", rx_byte, 0, "rx_byte reset");
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      rx_data = 1'($urandom);
      tx_byte = 8'($urandom);
      @(posedge clk);
      #1;
      quiet_check("R1");
    end
    // directed corners
    run_frame(32, 1, 1'b0, 8'hA5, 8'h3C);
    run_frame(32, 1, 1'b1, 8'h81, 8'hC3);
    run_frame(40, 30, 1'b1, 8'hFF, 8'h00);   // R2: long sync, no restart
    run_frame(36, 3, 1'b0, 8'h00, 8'hFF);
    // restart mid-frame: new edge at cycle 10 starts over (R2)
    run_frame(10, 1, 1'b1, 8'h12, 8'h34);
    run_frame(34, 2, 1'b0, 8'h5A, 8'h96);
    // random frames
    for (int f = 0; f < 60; f++) begin
      run_frame(32 + int'($urandom_range(0, 12)), int'($urandom_range(1, 5)),
                1'($urandom), 8'($urandom), 8'($urandom));
    end
    // long frame beyond saturation (R9)
    run_frame(300, 1, 1'b0, 8'h6E, 8'h71);
    // reset with fsync held high: no frame until a real edge (R1)
    @(negedge clk);
    fsync = 1'b1;
    rst   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    last_rx = '0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      rx_data = 1'($urandom);
      @(posedge clk);
      #1;
      quiet_check("R1");
      check("R1", rx_byte, 0, "rx_byte after reset");
    end
    @(negedge clk);
    fsync = 1'b0;
    run_frame(33, 1, 1'b1, 8'hB7, 8'h4D);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule